// File: doc/BRIEF.md
# Colour Map Register Port

This block holds a colour map of 256 pixel colours plus four overlay colours that a hardware cursor draws with, each entry made of 8-bit red, green and blue components. Software reaches it through a small 16-byte register window. A write to the index register selects an entry. Successive data accesses then move through that entry's red, green and blue components in that order. After the blue component the index steps to the next entry, so a whole palette can be loaded by streaming bytes. Reads walk the stored components in the same way.

The same three-step component counter serves pixel entries and overlay entries. A data write at the overlay offset targets overlay slot `index mod 4`, held after the 256 pixel entries. The display pipeline has its own lookup port. It takes any 9-bit entry number and returns the packed 24-bit colour in the same cycle.

Top module: `cmap_dac`

## Requirements
- R1: A write at byte offset 0 loads the index from `wdata[31:24]` and sets the component step to red, even in the middle of a triple.
- R2: A write at byte offset 4 stores `wdata[31:24]` into the current component of pixel entry `index`.
- R3: A write at byte offset 12 stores `wdata[31:24]` into the current component of overlay entry `256 + (index mod 4)`. The pixel entry `index` is not changed.
- R4: Each data access moves the step red → green → blue. After blue the step returns to red and the index increments, wrapping from 255 to 0.
- R5: A read pulse returns, on `rdata` in the following cycle, the current component of pixel entry `index` in bits 31:24 with bits 23:0 zero. It advances step and index as in R4.
- R6: Writes at any other byte offset (1–3, 5–11, 13–15) change no entry, index or step. When `wr_en` and `rd_en` are both high, only the write acts and `rdata` holds.
- R7: After reset every component is 0, except that entries 255, 256 and 258 are white (0xFF, 0xFF, 0xFF). Index, step and `rdata` are 0.
- R8: `lk_rgb` equals `{red, green, blue}` of entry `lk_idx` in the same cycle, red in bits 23:16. Entry numbers of 260 and above return 0.
- R9: Reads and writes share one step counter, so mixing them inside a triple continues the sequence and does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Data read strobe |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 32 | Write data; bytes carried in bits 31:24 |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| lk_idx | input | 9 | Display lookup entry number |
| lk_rgb | output | 24 | Colour of the looked-up entry |

## Verification
The bench builds the block with its defaults: an 8-bit index, four overlay slots and 8-bit components, giving 260 entries. At that size an exhaustive sweep is cheap. Every entry's reset colour is checked through the lookup port. All 768 pixel components are loaded with an arithmetic pattern in one stream and read back. The index wrap from 255 to 0, the overlay slot chosen from the low index bits, a step restart in mid-triple, and interleaved reads and writes are each driven from a known pattern value.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } step_t;

  function automatic step_t step_next(step_t s);
    case (s)
      STEP_RED: return STEP_GRN;
      STEP_GRN: return STEP_BLU;
      default:  return STEP_RED;
    endcase
  endfunction

  // overlay slot chosen from the low index bits, placed after pixel entries
  function automatic int unsigned ovl_entry(int unsigned idx, int unsigned n_pix,
                                            int unsigned n_ovl);
    return n_pix + (idx % n_ovl);
  endfunction

  // entries that come out of reset white
  function automatic bit reset_white(int unsigned e, int unsigned n_pix);
    return (e == n_pix - 1) || (e == n_pix) || (e == n_pix + 2);
  endfunction

endpackage

// File: rtl/cmap_seq.sv
module cmap_seq
  import cmap_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output step_t            phase,
  output logic             wrap_evt
);

  assign wrap_evt = step && (phase == STEP_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= STEP_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= STEP_RED;
    end else if (step) begin
      phase <= step_next(phase);
      if (wrap_evt) idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/cmap_store.sv
module cmap_store
  import cmap_pkg::*;
#(
  parameter int N_PIX  = 256,
  parameter int N_OVL  = 4,
  parameter int COMP_W = 8,
  localparam int ENT_N = N_PIX + N_OVL,
  localparam int SEL_W = $clog2(ENT_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SEL_W-1:0]    wsel,
  input  step_t               wph,
  input  logic [COMP_W-1:0]   wval,
  input  logic [SEL_W-1:0]    rsel,
  input  step_t               rph,
  output logic [COMP_W-1:0]   rcomp,
  input  logic [SEL_W-1:0]    lk_sel,
  output logic [3*COMP_W-1:0] lk_rgb
);

  logic [COMP_W-1:0] mem_r [ENT_N];
  logic [COMP_W-1:0] mem_g [ENT_N];
  logic [COMP_W-1:0] mem_b [ENT_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT_N; e++) begin
        mem_r[e] <= reset_white(e, N_PIX) ? '1 : '0;
        mem_g[e] <= reset_white(e, N_PIX) ? '1 : '0;
        mem_b[e] <= reset_white(e, N_PIX) ? '1 : '0;
      end
    end else if (we && (int'(wsel) < ENT_N)) begin
      case (wph)
        STEP_RED: mem_r[wsel] <= wval;
        STEP_GRN: mem_g[wsel] <= wval;
        default:  mem_b[wsel] <= wval;
      endcase
    end
  end

  always_comb begin
    rcomp = '0;
    if (int'(rsel) < ENT_N) begin
      case (rph)
        STEP_RED: rcomp = mem_r[rsel];
        STEP_GRN: rcomp = mem_g[rsel];
        default:  rcomp = mem_b[rsel];
      endcase
    end
  end

  always_comb begin
    lk_rgb = '0;
    if (int'(lk_sel) < ENT_N) lk_rgb = {mem_r[lk_sel], mem_g[lk_sel], mem_b[lk_sel]};
  end

endmodule

// File: rtl/cmap_dac.sv
module cmap_dac
  import cmap_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int N_OVL    = 4,
  parameter int COMP_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int OFS_IDX  = 0,
  parameter int OFS_PIX  = 4,
  parameter int OFS_OVL  = 12,
  localparam int N_PIX   = 2 ** IDX_W,
  localparam int ENT_N   = N_PIX + N_OVL,
  localparam int LK_W    = $clog2(ENT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LK_W-1:0]   lk_idx,
  output logic [3*COMP_W-1:0] lk_rgb
);

  // decoded bus events, named for the checker
  logic hit_idx, hit_pix, hit_ovl, rd_go, step;
  assign hit_idx = wr_en && (addr == ADDR_W'(OFS_IDX));
  assign hit_pix = wr_en && (addr == ADDR_W'(OFS_PIX));
  assign hit_ovl = wr_en && (addr == ADDR_W'(OFS_OVL));
  assign rd_go   = rd_en && !wr_en;
  assign step    = hit_pix || hit_ovl || rd_go;

  logic [IDX_W-1:0] cur_idx;
  step_t            cur_ph;
  logic             wrap_evt;

  cmap_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hit_idx),
    .load_val (wdata[DATA_W-1 -: IDX_W]),
    .step     (step),
    .idx      (cur_idx),
    .phase    (cur_ph),
    .wrap_evt (wrap_evt)
  );

  logic [LK_W-1:0]   wsel;
  logic [COMP_W-1:0] rcomp;
  assign wsel = hit_ovl ? LK_W'(ovl_entry(int'(cur_idx), N_PIX, N_OVL))
                        : LK_W'(cur_idx);

  cmap_store #(.N_PIX(N_PIX), .N_OVL(N_OVL), .COMP_W(COMP_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (hit_pix || hit_ovl),
    .wsel   (wsel),
    .wph    (cur_ph),
    .wval   (wdata[DATA_W-1 -: COMP_W]),
    .rsel   (LK_W'(cur_idx)),
    .rph    (cur_ph),
    .rcomp  (rcomp),
    .lk_sel (lk_idx),
    .lk_rgb (lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= {rcomp, {(DATA_W-COMP_W){1'b0}}};
  end

endmodule

// File: rtl/cmap_dac_chk.sv
module cmap_dac_chk #(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int OFS_IDX = 0,
  parameter int OFS_PIX = 4,
  parameter int OFS_OVL = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        cur_ph,
  input logic              step,
  input logic              wrap_evt
);

  logic odd_ofs;
  assign odd_ofs = wr_en && (addr != ADDR_W'(OFS_IDX)) && (addr != ADDR_W'(OFS_PIX))
                         && (addr != ADDR_W'(OFS_OVL));

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_IDX)) |=>
      (cur_idx == $past(wdata[DATA_W-1 -: IDX_W])) && (cur_ph == 2'd0));

  assert_step_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ph != 2'd3);

  assert_wrap_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cur_ph == 2'd0) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  assert_inner_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_ph != 2'd2) |=>
      $stable(cur_idx) && (cur_ph == 2'($past(cur_ph) + 1'b1)));

  assert_odd_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    odd_ofs |=> $stable(cur_idx) && $stable(cur_ph));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(rdata));

  assert_read_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (rdata[DATA_W-COMP_W-1:0] == '0));

endmodule

bind cmap_dac cmap_dac_chk #(
  .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .OFS_IDX(OFS_IDX), .OFS_PIX(OFS_PIX), .OFS_OVL(OFS_OVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cur_idx(cur_idx), .cur_ph(cur_ph),
  .step(step), .wrap_evt(wrap_evt)
);

// File: tb/tb_cmap_dac.sv
module tb_cmap_dac;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmap_dac dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  function automatic logic [7:0] pat(int e, int c);
    return 8'((e * 7 + c * 53 + 1) & 255);
  endfunction

  function automatic logic [23:0] pat_rgb(int e);
    return {pat(e, 0), pat(e, 1), pat(e, 2)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = {b, 24'h5A5A5A};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic look(int e, string req, logic [23:0] exp);
    @(negedge clk);
    lk_idx = 9'(e);
    #1;
    check(req, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset contents over all 260 entries
    check("R7 rdata", rdata, 32'h0);
    for (int e = 0; e < 260; e++)
      look(e, "R7 reset colour",
           (e == 255 || e == 256 || e == 258) ? 24'hFFFFFF : 24'h0);

    // R2/R4: stream all pixel components from index 0
    wr(4'd0, 8'd0);
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) wr(4'd4, pat(e, c));
    for (int e = 0; e < 256; e++) look(e, "R2 pixel store", pat_rgb(e));
    look(256, "R3 overlay untouched", 24'hFFFFFF);
    look(257, "R3 overlay untouched", 24'h0);

    // R5/R4: index wrapped to 0; stream everything back
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) begin
        rd(v);
        check("R5 read stream", v, {pat(e, c), 24'h0});
      end

    // R3: overlay slot from index mod 4
    wr(4'd0, 8'h05);
    wr(4'd12, 8'hA1); wr(4'd12, 8'hB2); wr(4'd12, 8'hC3);
    look(257, "R3 overlay slot 1", 24'hA1B2C3);
    look(5, "R3 pixel entry kept", pat_rgb(5));
    wr(4'd12, 8'h44);  // index now 6 -> slot 2
    look(258, "R3 R4 next overlay slot", 24'h44FFFF);

    // R4: wrap 255 -> 0
    wr(4'd0, 8'hFF);
    wr(4'd4, 8'h10); wr(4'd4, 8'h20); wr(4'd4, 8'h30);
    wr(4'd4, 8'h5A);
    look(255, "R4 last entry", 24'h102030);
    look(0, "R4 wrap to entry 0", {8'h5A, pat(0, 1), pat(0, 2)});

    // R1: index reload mid-triple restarts at red
    wr(4'd0, 8'd50); wr(4'd4, 8'h01);
    wr(4'd0, 8'd51); wr(4'd4, 8'h02);
    look(50, "R1 partial entry", {8'h01, pat(50, 1), pat(50, 2)});
    look(51, "R1 restart red", {8'h02, pat(51, 1), pat(51, 2)});

    // R9: reads and writes share the step counter
    wr(4'd0, 8'd20); wr(4'd4, 8'hAA);
    rd(v);
    check("R9 read takes green", v, {pat(20, 1), 24'h0});
    wr(4'd4, 8'hBB);
    look(20, "R9 mixed triple", {8'hAA, pat(20, 1), 8'hBB});
    wr(4'd4, 8'hCC);
    look(21, "R9 index advanced", {8'hCC, pat(21, 1), pat(21, 2)});

    // R6: simultaneous read and write -> write only, rdata holds
    wr(4'd0, 8'd40);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 4'd4; wdata = 32'h77000000;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6 rdata held", rdata, {pat(20, 1), 24'h0});
    wr(4'd4, 8'h78);
    look(40, "R6 write wins", {8'h77, 8'h78, pat(40, 2)});

    // R6: other offsets ignored
    wr(4'd0, 8'd30); wr(4'd4, 8'h11);
    for (int a = 1; a < 16; a++)
      if (a != 4 && a != 12 && a != 0) wr(4'(a), 8'h99);
    wr(4'd4, 8'h22);
    look(30, "R6 odd offsets ignored", {8'h11, 8'h22, pat(30, 2)});
    look(31, "R6 neighbour intact", pat_rgb(31));

    // R8: out of range lookups
    look(260, "R8 beyond map", 24'h0);
    look(300, "R8 beyond map", 24'h0);
    look(511, "R8 beyond map", 24'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule